// File: doc/BRIEF.md
# Granule Tag Range Checker

The block verifies that a memory access may proceed by comparing the 4-bit tag carried in the access pointer with the allocation tags stored for each 16-byte granule the access covers. Allocation tags live in a separate tag memory, packed two per byte: the even-numbered granule of each pair sits in the low nibble and the odd one in the high nibble. The checker works out how many granules the access spans, reads the tag bytes one per cycle through a simple read port with one cycle of latency, and stops at the first tag that disagrees.

A request gives the pointer, the access size minus one, a scan direction and a flag saying whether the pointer's top byte is tag-checked. A forward request treats the pointer as the lowest byte accessed. A reverse request treats it as the highest byte and walks toward lower addresses, as a backward copy does. When the scan ends, a one-cycle done strobe comes with a pass flag, the count of consecutive granules that matched, and the address of the failing granule.

Top module: `granule_tag_checker`

## Requirements
- R1: The tag byte for a granule is read at tag-memory address (granule address >> 5). Bit 4 of the granule address selects the nibble: 0 selects bits [3:0] and 1 selects bits [7:4]. The pointer tag is bits [59:56] of the pointer.
- R2: The number of granules checked is ((last >> 4) - (first >> 4)) + 1. A forward access has first = pointer and last = pointer + size_m1. A reverse access has first = pointer - size_m1 and last = pointer.
- R3: A forward scan starts at the pointer's granule. If bit 4 is set, it checks only the high nibble of that byte. Otherwise it checks the low nibble and then the high nibble. It then steps through successive tag bytes, each one address above the last.
- R4: The result count is the number of consecutive matching granules from the start of the scan, and pass is 1 only when that count equals the R2 granule count. Results hold until the next accepted request completes.
- R5: On a forward failure, the fault address is the pointer itself if the first granule failed. Otherwise it is the aligned first granule address plus 16 times the result count.
- R6: A reverse scan starts at the granule holding the pointer and moves to lower addresses. Within a byte it checks the high nibble before the low nibble, and each later tag byte is one address below the last.
- R7: On a reverse failure, the fault address is the pointer itself if the first granule failed. Otherwise it is the aligned last granule address minus 16 times the result count, plus 15 (the last byte of the failing granule).
- R8: With top-byte checking disabled, a request makes no tag-memory read and completes on the next cycle with pass = 1 and count = 0.
- R9: One tag byte is requested per cycle while scanning, a request is made only while busy, and done is a single-cycle strobe raised only once the scan is complete. The number of reads equals the number of distinct tag bytes visited before the scan stops.
- R10: After reset, busy, done and the tag-memory request are all low.
- R11: A start pulse that arrives while a scan is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request strobe, accepted when idle |
| ptr_i | input | AW | Access pointer, tag in bits [59:56] |
| size_m1_i | input | SW | Access size in bytes minus one |
| reverse_i | input | 1 | 1 = scan downward from the pointer |
| tbi_en_i | input | 1 | 1 = the pointer's top byte is tag-checked |
| tmem_req_o | output | 1 | Tag-memory read request |
| tmem_addr_o | output | TAW | Tag-memory byte address |
| tmem_data_i | input | 8 | Tag byte, valid the cycle after the request |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle completion strobe |
| pass_o | output | 1 | All granules matched |
| match_cnt_o | output | CW | Consecutive matching granules |
| fault_addr_o | output | AW | Address reported on failure |

## Verification
The hardest cases to reach from the ports are scans that fail partway through a tag byte, and reverse scans that begin on a low nibble and so check only one tag in their first byte. The tag-memory model holds the pointer's tag everywhere except at two planted granules. The stimulus places access windows so that these granules fall at the first position, in the middle of a byte and across a byte boundary, in both directions. The bench also counts read requests and records the first request address, which shows how many bytes the scan visited and where it began.

// File: rtl/granule_tag_pkg.sv
package granule_tag_pkg;
  localparam int GRAN_LG = 4;
  localparam int TAG_LSB = 56;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_CMP
  } scan_st_e;
endpackage

// File: rtl/granule_tag_span.sv
module granule_tag_span #(
  parameter int AW = 64,
  parameter int SW = 12,
  parameter int CW = 9
) (
  input  logic [AW-1:0] ptr,
  input  logic [SW-1:0] size_m1,
  input  logic          reverse,
  output logic [AW-1:0] lo_gran,
  output logic [AW-1:0] hi_gran,
  output logic [CW-1:0] gran_cnt
);
  import granule_tag_pkg::*;

  logic [AW-1:0] lo_byte, hi_byte, span;

  always_comb begin
    if (reverse) begin
      lo_byte = ptr - AW'(size_m1);
      hi_byte = ptr;
    end else begin
      lo_byte = ptr;
      hi_byte = ptr + AW'(size_m1);
    end
    lo_gran  = {lo_byte[AW-1:GRAN_LG], {GRAN_LG{1'b0}}};
    hi_gran  = {hi_byte[AW-1:GRAN_LG], {GRAN_LG{1'b0}}};
    span     = (hi_byte >> GRAN_LG) - (lo_byte >> GRAN_LG);
    gran_cnt = CW'(span) + CW'(1);
  end
endmodule

// File: rtl/granule_tag_pair.sv
module granule_tag_pair (
  input  logic [7:0] tag_byte,
  input  logic [3:0] ptr_tag,
  input  logic       first_hi,
  input  logic       allow_two,
  output logic       use_two,
  output logic [1:0] hits
);
  logic [3:0] nib_a, nib_b;
  logic       eq_a, eq_b;

  always_comb begin
    nib_a   = first_hi ? tag_byte[7:4] : tag_byte[3:0];
    nib_b   = first_hi ? tag_byte[3:0] : tag_byte[7:4];
    eq_a    = (nib_a == ptr_tag);
    eq_b    = (nib_b == ptr_tag);
    use_two = allow_two;
    if (!eq_a)                hits = 2'd0;
    else if (allow_two && eq_b) hits = 2'd2;
    else                      hits = 2'd1;
  end
endmodule

// File: rtl/granule_tag_checker.sv
module granule_tag_checker #(
  parameter int AW  = 64,
  parameter int SW  = 12,
  parameter int TAW = 16,
  parameter int CW  = SW - granule_tag_pkg::GRAN_LG + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic [AW-1:0]  ptr_i,
  input  logic [SW-1:0]  size_m1_i,
  input  logic           reverse_i,
  input  logic           tbi_en_i,
  output logic           tmem_req_o,
  output logic [TAW-1:0] tmem_addr_o,
  input  logic [7:0]     tmem_data_i,
  output logic           busy_o,
  output logic           done_o,
  output logic           pass_o,
  output logic [CW-1:0]  match_cnt_o,
  output logic [AW-1:0]  fault_addr_o
);
  import granule_tag_pkg::*;

  localparam int BYTE_LSB = GRAN_LG + 1;
  localparam logic [AW-1:0] GSTEP = AW'(1) << GRAN_LG;
  localparam logic [AW-1:0] GLAST = GSTEP - AW'(1);

  scan_st_e      st_q, st_d;
  logic [AW-1:0] cur_q, cur_d, base_q, base_d, ptr_q, ptr_d;
  logic [AW-1:0] fault_q, fault_d;
  logic [CW-1:0] cnt_q, cnt_d, mat_q, mat_d, res_q, res_d;
  logic          rev_q, rev_d, done_q, done_d, pass_q, pass_d;

  logic [AW-1:0] lo_gran, hi_gran, step, mshift;
  logic [CW-1:0] gran_cnt, new_mat;
  logic          use_two, allow_two, fail, finish, req;
  logic [1:0]    hits;

  granule_tag_span #(.AW(AW), .SW(SW), .CW(CW)) u_span (
    .ptr      (ptr_i),
    .size_m1  (size_m1_i),
    .reverse  (reverse_i),
    .lo_gran  (lo_gran),
    .hi_gran  (hi_gran),
    .gran_cnt (gran_cnt)
  );

  assign allow_two = (rev_q ? cur_q[GRAN_LG] : ~cur_q[GRAN_LG]) &&
                     ((cnt_q - mat_q) > CW'(1));

  granule_tag_pair u_pair (
    .tag_byte  (tmem_data_i),
    .ptr_tag   (ptr_q[TAG_LSB +: 4]),
    .first_hi  (cur_q[GRAN_LG]),
    .allow_two (allow_two),
    .use_two   (use_two),
    .hits      (hits)
  );

  always_comb begin
    new_mat = mat_q + CW'(hits);
    fail    = (hits != (use_two ? 2'd2 : 2'd1));
    finish  = fail || (new_mat == cnt_q);
    step    = use_two ? (GSTEP << 1) : GSTEP;
    mshift  = AW'(new_mat) << GRAN_LG;
  end

  always_comb begin
    st_d    = st_q;
    cur_d   = cur_q;
    base_d  = base_q;
    ptr_d   = ptr_q;
    cnt_d   = cnt_q;
    mat_d   = mat_q;
    rev_d   = rev_q;
    res_d   = res_q;
    pass_d  = pass_q;
    fault_d = fault_q;
    done_d  = 1'b0;
    req     = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          if (!tbi_en_i) begin
            done_d  = 1'b1;
            pass_d  = 1'b1;
            res_d   = '0;
            fault_d = '0;
          end else begin
            st_d   = ST_FETCH;
            ptr_d  = ptr_i;
            rev_d  = reverse_i;
            cnt_d  = gran_cnt;
            mat_d  = '0;
            cur_d  = reverse_i ? hi_gran : lo_gran;
            base_d = reverse_i ? hi_gran : lo_gran;
          end
        end
      end
      ST_FETCH: begin
        req  = 1'b1;
        st_d = ST_CMP;
      end
      ST_CMP: begin
        if (finish) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
          pass_d = !fail;
          res_d  = new_mat;
          if (!fail)                fault_d = '0;
          else if (new_mat == '0)   fault_d = ptr_q;
          else if (rev_q)           fault_d = base_q - mshift + GLAST;
          else                      fault_d = base_q + mshift;
        end else begin
          mat_d = new_mat;
          cur_d = rev_q ? (cur_q - step) : (cur_q + step);
          req   = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cur_q   <= '0;
      base_q  <= '0;
      ptr_q   <= '0;
      cnt_q   <= '0;
      mat_q   <= '0;
      rev_q   <= 1'b0;
      res_q   <= '0;
      pass_q  <= 1'b0;
      fault_q <= '0;
      done_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      if (st_q != ST_IDLE || start_i) begin
        cur_q   <= cur_d;
        base_q  <= base_d;
        ptr_q   <= ptr_d;
        cnt_q   <= cnt_d;
        mat_q   <= mat_d;
        rev_q   <= rev_d;
        res_q   <= res_d;
        pass_q  <= pass_d;
        fault_q <= fault_d;
      end
    end
  end

  assign tmem_req_o   = req;
  assign tmem_addr_o  = cur_d[BYTE_LSB +: TAW];
  assign busy_o       = (st_q != ST_IDLE);
  assign done_o       = done_q;
  assign pass_o       = pass_q;
  assign match_cnt_o  = res_q;
  assign fault_addr_o = fault_q;
endmodule

// File: rtl/granule_tag_checker_sva.sv
module granule_tag_checker_sva #(
  parameter int TAW = 16,
  parameter int CW  = 9
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start_i,
  input logic           tbi_en_i,
  input logic           tmem_req_o,
  input logic [TAW-1:0] tmem_addr_o,
  input logic           busy_o,
  input logic           done_o,
  input logic           pass_o,
  input logic [CW-1:0]  match_cnt_o
);
  // R9
  req_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmem_req_o |-> busy_o);

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R3 R6
  adjacent_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmem_req_o && $past(tmem_req_o)) |->
      ((tmem_addr_o == $past(tmem_addr_o) + TAW'(1)) ||
       (tmem_addr_o == $past(tmem_addr_o) - TAW'(1))));

  // R8
  bypass_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i && !tbi_en_i) |=>
      (done_o && pass_o && match_cnt_o == '0));

  // R4
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> ($stable(match_cnt_o) && $stable(pass_o)));
endmodule

bind granule_tag_checker granule_tag_checker_sva #(.TAW(TAW), .CW(CW)) u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .tbi_en_i    (tbi_en_i),
  .tmem_req_o  (tmem_req_o),
  .tmem_addr_o (tmem_addr_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .pass_o      (pass_o),
  .match_cnt_o (match_cnt_o)
);

// File: tb/granule_tag_checker_test.sv
module granule_tag_checker_test;
  localparam int PERIOD = 10;
  localparam int AW  = 64;
  localparam int SW  = 12;
  localparam int TAW = 16;
  localparam int CW  = 9;

  typedef struct packed {
    logic [11:0] addr;
    logic [11:0] sz;
    logic [3:0]  tag;
    logic        rev;
    logic        tbi;
    logic        epass;
    logic [8:0]  ecnt;
    logic [11:0] efault;
    logic [3:0]  ereads;
  } vec_t;

  // memory: tag 5 everywhere, granule 11 holds 3, granule 40 holds 9
  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{12'h000, 12'h00F, 4'h5, 1'b0, 1'b1, 1'b1, 9'd1, 12'h000, 4'd1},
    '{12'h008, 12'h00F, 4'h5, 1'b0, 1'b1, 1'b1, 9'd2, 12'h000, 4'd1},
    '{12'h018, 12'h027, 4'h5, 1'b0, 1'b1, 1'b1, 9'd3, 12'h000, 4'd2},
    '{12'h090, 12'h03F, 4'h5, 1'b0, 1'b1, 1'b0, 9'd2, 12'h0B0, 4'd2},
    '{12'h0B4, 12'h000, 4'h5, 1'b0, 1'b1, 1'b0, 9'd0, 12'h0B4, 4'd1},
    '{12'h0B0, 12'h00F, 4'h3, 1'b0, 1'b1, 1'b1, 9'd1, 12'h000, 4'd1},
    '{12'h0CF, 12'h03F, 4'h5, 1'b1, 1'b1, 1'b0, 9'd1, 12'h0BF, 4'd2},
    '{12'h2A8, 12'h02F, 4'h5, 1'b1, 1'b1, 1'b0, 9'd2, 12'h28F, 4'd2},
    '{12'h0C5, 12'h000, 4'h5, 1'b1, 1'b1, 1'b1, 9'd1, 12'h000, 4'd1},
    '{12'h0B0, 12'h00F, 4'h5, 1'b0, 1'b0, 1'b1, 9'd0, 12'h000, 4'd0},
    '{12'h280, 12'h000, 4'h9, 1'b0, 1'b1, 1'b1, 9'd1, 12'h000, 4'd1},
    '{12'h3F8, 12'h01F, 4'h5, 1'b0, 1'b1, 1'b1, 9'd3, 12'h000, 4'd2}
  };

  logic           clk, rst_n, start_i, reverse_i, tbi_en_i;
  logic [AW-1:0]  ptr_i;
  logic [SW-1:0]  size_m1_i;
  logic           tmem_req_o, busy_o, done_o, pass_o;
  logic [TAW-1:0] tmem_addr_o;
  logic [7:0]     tmem_data_i;
  logic [CW-1:0]  match_cnt_o;
  logic [AW-1:0]  fault_addr_o;

  logic [7:0] tmem [64];
  int compared, mismatched, reads;
  logic [TAW-1:0] first_addr;

  granule_tag_checker #(.AW(AW), .SW(SW), .TAW(TAW)) uut (
    .clk, .rst_n, .start_i, .ptr_i, .size_m1_i, .reverse_i, .tbi_en_i,
    .tmem_req_o, .tmem_addr_o, .tmem_data_i, .busy_o, .done_o, .pass_o,
    .match_cnt_o, .fault_addr_o
  );

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  always @(posedge clk) if (tmem_req_o) tmem_data_i <= tmem[tmem_addr_o[5:0]];

  always @(negedge clk) if (tmem_req_o) begin
    if (reads == 0) first_addr = tmem_addr_o;
    reads = reads + 1;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mkptr(input logic [3:0] tag, input logic [11:0] a);
    return {4'h0, tag, 44'h0, a};
  endfunction

  task automatic launch(input vec_t v);
    @(negedge clk);
    ptr_i = mkptr(v.tag, v.addr);
    size_m1_i = v.sz;
    reverse_i = v.rev;
    tbi_en_i = v.tbi;
    reads = 0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done();
    int guard = 0;
    while (!done_o && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
    if (!done_o) begin
      compared++;
      mismatched++;
      $display("FAIL R9: actual no done expected done");
    end
  endtask

  task automatic check_vec(input vec_t v);
    check(v.rev ? "R4 R6 count" : "R4 R3 count", 64'(match_cnt_o), 64'(v.ecnt));
    check(v.tbi ? "R4 pass" : "R8 pass", 64'(pass_o), 64'(v.epass));
    if (!v.epass)
      check(v.rev ? "R7 fault" : "R5 fault", fault_addr_o, mkptr(v.tag, v.efault));
    check(v.tbi ? "R9 reads" : "R8 reads", 64'(reads), 64'(v.ereads));
    if (v.ereads != 0)
      check("R1 first tag byte", 64'(first_addr), 64'(v.addr >> 5));
  endtask

  initial begin
    #(PERIOD * 200000);
    mismatched++;
    compared++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    compared = 0;
    mismatched = 0;
    reads = 0;
    first_addr = '0;
    for (int i = 0; i < 64; i++) tmem[i] = 8'h55;
    tmem[5]  = 8'h35;
    tmem[20] = 8'h59;
    start_i = 1'b0; ptr_i = '0; size_m1_i = '0; reverse_i = 1'b0; tbi_en_i = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 busy", 64'(busy_o), 64'd0);
    check("R10 done", 64'(done_o), 64'd0);
    check("R10 req", 64'(tmem_req_o), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      launch(VECS[i]);
      wait_done();
      check_vec(VECS[i]);
      @(negedge clk);
      // R4 results held after done
      check("R4 hold", 64'(match_cnt_o), 64'(VECS[i].ecnt));
    end

    // R11: second start during a scan is ignored
    launch(VECS[3]);
    check("R11 busy", 64'(busy_o), 64'd1);
    ptr_i = mkptr(4'h5, 12'h000);
    size_m1_i = 12'h000;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_done();
    check_vec(VECS[3]);
    check("R11 ignored start", 64'(reads), 64'd2);

    // R2: long forward span, tag 5 over bytes 6..15 (granules 12..31)
    launch('{12'h0C0, 12'h13F, 4'h5, 1'b0, 1'b1, 1'b1, 9'd20, 12'h000, 4'd10});
    wait_done();
    check("R2 span count", 64'(match_cnt_o), 64'd20);
    check("R2 span pass", 64'(pass_o), 64'd1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule